// File: doc/BRIEF.md
# Register Frame Cache Spill Controller

This block keeps track of how many local-register frames sit in a small on-chip frame cache, and decides when the oldest resident frame has to be written out to the external stack. A call or an implicit interrupt call pushes a frame, and a return pops one. A flush command drains every resident frame. The block stores no register data. It names the slot to spill or asks for a fill, and then waits for the memory side to acknowledge the request.

Some free frames can be held back for critical code. Critical code is code that runs in the interrupted state at a priority of at least 28. A 3-bit reserved count R, sampled at every push, pulls the spill threshold down for all other code. Critical code still spills, but only when all slots are full. Slots are used as a ring with a newest pointer and an oldest pointer, so a spill always hands out the slot that has been resident longest.

Top module: `frame_cache_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `occupancy` is 0, `ready` is 1, `spill_req`, `fill_req` and `flush_done` are 0, and `spill_slot` is 0.
- R2: An accepted push that needs no spill raises `occupancy` by one on the next cycle. An accepted pop with `occupancy` above 0 lowers it by one. `occupancy` never exceeds 8.
- R3: A push that brings `occupancy` to 8 raises `spill_req` on the next cycle, whatever the priority or state.
- R4: A push from non-critical code (`cur_intr` is 0, or `cur_prio` is below 28) raises `spill_req` when the new occupancy plus `rsv_frames` is at least 8, that is, when more than 7 − R frames would be resident.
- R5: A push from critical code (`cur_intr` is 1 and `cur_prio` is at least 28) spills only when the new occupancy is 8.
- R6: `spill_req` and `spill_slot` stay constant until `spill_ack`. Each acknowledged spill lowers `occupancy` by one. Successive spills name the slots oldest-first, starting from slot 0 after reset and advancing by one modulo 8.
- R7: `ready` is 0 exactly while a spill or a fill is outstanding. While it is 0, push, pop and flush requests are ignored and `occupancy` does not change until an acknowledge arrives.
- R8: A pop at `occupancy` 0 raises `fill_req`, which is held until `fill_ack`. After the fill, `occupancy` is still 0 and `ready` returns to 1.
- R9: A flush spills every resident frame oldest-first, one per `spill_ack`. On the cycle after the last acknowledge, `occupancy` is 0 and `flush_done` is a one-cycle pulse. A flush at `occupancy` 0 pulses `flush_done` on the next cycle.
- R10: `rsv_frames` is used only when a push is accepted. Changing it and then popping causes no spill. With R = 7, every non-critical push spills.
- R11: When requests arrive together in the ready state, flush takes precedence over push, and push takes precedence over pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Call or implicit interrupt call pushes a frame |
| pop_req | input | 1 | Return pops a frame |
| flush_req | input | 1 | Spill every resident frame |
| rsv_frames | input | 3 | Free frames reserved for critical code (R) |
| cur_prio | input | 5 | Priority of the pushing context |
| cur_intr | input | 1 | Pushing context is in the interrupted state |
| spill_ack | input | 1 | Memory side has stored the named slot |
| fill_ack | input | 1 | Memory side has restored the caller frame |
| ready | output | 1 | Block accepts push, pop or flush |
| spill_req | output | 1 | Request to store slot `spill_slot` |
| spill_slot | output | 3 | Index of the oldest resident slot |
| fill_req | output | 1 | Request to restore a frame on a pop at empty |
| flush_done | output | 1 | One-cycle pulse when a flush has drained the cache |
| occupancy | output | 4 | Number of resident frames |

## Verification
The assertions check the following on every cycle:
- the occupancy bound and ring consistency;
- the push-time spill decisions for the full cache, for non-critical code past the threshold, and for the exemption of critical code;
- that spill and fill requests are held until acknowledged, and that occupancy is frozen while stalled;
- flush precedence and that occupancy is zero at `flush_done`.

Only the bench scenarios can show:
- the exact oldest-first sequence of slot indices across ring wrap-around, compared by a scoreboard;
- a complete flush drain;
- that a change of R takes effect only at the next call;
- the R = 7 case, where every non-critical call spills.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    FCC_IDLE  = 2'd0,
    FCC_SPILL = 2'd1,
    FCC_FILL  = 2'd2,
    FCC_DRAIN = 2'd3
  } fcc_state_e;
endpackage

// File: rtl/fcc_spill_policy.sv
// Decides at push time whether the oldest frame must leave the cache.
module fcc_spill_policy #(
  parameter int NUM_SLOTS = 8,
  parameter int PRIO_W    = 5,
  parameter int CRIT_PRIO = 28,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int RSV_W    = $clog2(NUM_SLOTS)
) (
  input  logic [CNT_W-1:0]  count_cur,
  input  logic [RSV_W-1:0]  rsv_frames,
  input  logic [PRIO_W-1:0] ctx_prio,
  input  logic              ctx_intr,
  output logic              need_spill
);
  localparam int SUM_W = CNT_W + RSV_W + 1;

  logic [SUM_W-1:0] count_after;
  logic [SUM_W-1:0] count_plus_rsv;
  logic             ctx_critical;
  logic             hits_full;
  logic             hits_reserve;

  always_comb begin
    count_after    = SUM_W'(count_cur) + SUM_W'(1);
    count_plus_rsv = count_after + SUM_W'(rsv_frames);
    ctx_critical   = ctx_intr && (ctx_prio >= PRIO_W'(CRIT_PRIO));
    hits_full      = count_after >= SUM_W'(NUM_SLOTS);
    hits_reserve   = count_plus_rsv >= SUM_W'(NUM_SLOTS);
    need_spill     = hits_full || (!ctx_critical && hits_reserve);
  end
endmodule

// File: rtl/fcc_slot_ring.sv
// Newest/oldest slot pointers and resident count of the frame ring.
module fcc_slot_ring #(
  parameter int NUM_SLOTS = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_push,
  input  logic             do_pop,
  input  logic             do_retire,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] head_ptr,
  output logic [IDX_W-1:0] oldest_ptr
);
  localparam bit POW2 = (NUM_SLOTS == (1 << IDX_W));

  logic [IDX_W-1:0] head_inc, head_dec, oldest_inc;
  logic [IDX_W-1:0] head_nxt, oldest_nxt;
  logic [CNT_W-1:0] count_nxt;
  logic             head_en, oldest_en, count_en;

  generate
    if (POW2) begin : g_wrap_free
      assign head_inc   = head_ptr + IDX_W'(1);
      assign head_dec   = head_ptr - IDX_W'(1);
      assign oldest_inc = oldest_ptr + IDX_W'(1);
    end else begin : g_wrap_cmp
      assign head_inc   = (head_ptr == IDX_W'(NUM_SLOTS - 1)) ? '0 : head_ptr + IDX_W'(1);
      assign head_dec   = (head_ptr == '0) ? IDX_W'(NUM_SLOTS - 1) : head_ptr - IDX_W'(1);
      assign oldest_inc = (oldest_ptr == IDX_W'(NUM_SLOTS - 1)) ? '0 : oldest_ptr + IDX_W'(1);
    end
  endgenerate

  always_comb begin
    head_en    = do_push || do_pop;
    head_nxt   = do_push ? head_inc : head_dec;
    oldest_en  = do_retire;
    oldest_nxt = oldest_inc;
    count_en   = do_push || do_pop || do_retire;
    count_nxt  = do_push ? count + CNT_W'(1) : count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr   <= '0;
      oldest_ptr <= '0;
      count      <= '0;
    end else begin
      if (head_en)   head_ptr   <= head_nxt;
      if (oldest_en) oldest_ptr <= oldest_nxt;
      if (count_en)  count      <= count_nxt;
    end
  end
endmodule

// File: rtl/fcc_sequencer.sv
// Accepts requests, runs the spill/fill handshakes and drains on flush.
module fcc_sequencer
  import fcc_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush_req,
  input  logic             need_spill,
  input  logic [CNT_W-1:0] count,
  input  logic             spill_ack,
  input  logic             fill_ack,
  output logic             do_push,
  output logic             do_pop,
  output logic             do_retire,
  output logic             ready,
  output logic             spill_req,
  output logic             fill_req,
  output logic             flush_done
);
  fcc_state_e state, state_nxt;
  logic       done_nxt;

  always_comb begin
    state_nxt = state;
    done_nxt  = 1'b0;
    do_push   = 1'b0;
    do_pop    = 1'b0;
    do_retire = 1'b0;
    unique case (state)
      FCC_IDLE: begin
        if (flush_req) begin
          if (count == '0) done_nxt  = 1'b1;
          else             state_nxt = FCC_DRAIN;
        end else if (push_req) begin
          do_push = 1'b1;
          if (need_spill) state_nxt = FCC_SPILL;
        end else if (pop_req) begin
          if (count == '0) state_nxt = FCC_FILL;
          else             do_pop    = 1'b1;
        end
      end
      FCC_SPILL: begin
        if (spill_ack) begin
          do_retire = 1'b1;
          state_nxt = FCC_IDLE;
        end
      end
      FCC_FILL: begin
        if (fill_ack) state_nxt = FCC_IDLE;
      end
      FCC_DRAIN: begin
        if (spill_ack) begin
          do_retire = 1'b1;
          if (count == CNT_W'(1)) begin
            state_nxt = FCC_IDLE;
            done_nxt  = 1'b1;
          end
        end
      end
      default: state_nxt = FCC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FCC_IDLE;
      flush_done <= 1'b0;
    end else begin
      state      <= state_nxt;
      flush_done <= done_nxt;
    end
  end

  always_comb begin
    ready     = (state == FCC_IDLE);
    spill_req = (state == FCC_SPILL) || (state == FCC_DRAIN);
    fill_req  = (state == FCC_FILL);
  end
endmodule

// File: rtl/frame_cache_ctrl.sv
module frame_cache_ctrl #(
  parameter int NUM_SLOTS = 8,
  parameter int PRIO_W    = 5,
  parameter int CRIT_PRIO = 28,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              flush_req,
  input  logic [IDX_W-1:0]  rsv_frames,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              cur_intr,
  input  logic              spill_ack,
  input  logic              fill_ack,
  output logic              ready,
  output logic              spill_req,
  output logic [IDX_W-1:0]  spill_slot,
  output logic              fill_req,
  output logic              flush_done,
  output logic [CNT_W-1:0]  occupancy
);
  logic             need_spill;
  logic             do_push, do_pop, do_retire;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] head_ptr, oldest_ptr;

  fcc_spill_policy #(
    .NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W), .CRIT_PRIO(CRIT_PRIO)
  ) i_policy (
    .count_cur (count),
    .rsv_frames(rsv_frames),
    .ctx_prio  (cur_prio),
    .ctx_intr  (cur_intr),
    .need_spill(need_spill)
  );

  fcc_slot_ring #(.NUM_SLOTS(NUM_SLOTS)) i_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .do_retire (do_retire),
    .count     (count),
    .head_ptr  (head_ptr),
    .oldest_ptr(oldest_ptr)
  );

  fcc_sequencer #(.NUM_SLOTS(NUM_SLOTS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .flush_req (flush_req),
    .need_spill(need_spill),
    .count     (count),
    .spill_ack (spill_ack),
    .fill_ack  (fill_ack),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .do_retire (do_retire),
    .ready     (ready),
    .spill_req (spill_req),
    .fill_req  (fill_req),
    .flush_done(flush_done)
  );

  assign spill_slot = oldest_ptr;
  assign occupancy  = count;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int PRIO_W    = 5,
  parameter int CRIT_PRIO = 28,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_req,
  input logic              pop_req,
  input logic              flush_req,
  input logic [IDX_W-1:0]  rsv_frames,
  input logic [PRIO_W-1:0] cur_prio,
  input logic              cur_intr,
  input logic              spill_ack,
  input logic              fill_ack,
  input logic              ready,
  input logic              spill_req,
  input logic [IDX_W-1:0]  spill_slot,
  input logic              fill_req,
  input logic              flush_done,
  input logic [CNT_W-1:0]  occupancy,
  input logic [IDX_W-1:0]  head_ptr
);
  logic push_acc, crit_ctx;
  int   ring_gap;
  assign push_acc = ready && push_req && !flush_req;
  assign crit_ctx = cur_intr && (int'(cur_prio) >= CRIT_PRIO);
  assign ring_gap = (int'(head_ptr) + NUM_SLOTS - int'(spill_slot)) % NUM_SLOTS;

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= NUM_SLOTS);

  a_r2_ring_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    ring_gap == int'(occupancy) % NUM_SLOTS);

  a_r3_full_push_spills: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && int'(occupancy) == NUM_SLOTS - 1 |=> spill_req);

  a_r4_low_prio_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && !crit_ctx && (int'(occupancy) + 1 + int'(rsv_frames) >= NUM_SLOTS)
    |=> spill_req);

  a_r5_critical_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc && crit_ctx && int'(occupancy) < NUM_SLOTS - 1 |=> !spill_req);

  a_r6_spill_held: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req && !spill_ack |=> spill_req && $stable(spill_slot));

  a_r6_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req && spill_ack |=> int'(occupancy) == int'($past(occupancy)) - 1);

  a_r7_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !spill_ack && !fill_ack |=> $stable(occupancy) && !ready);

  a_r7_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && (spill_req || fill_req)));

  a_r8_fill_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ready && pop_req && !push_req && !flush_req && occupancy == '0 |=> fill_req);

  a_r8_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req);

  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> occupancy == '0);

  a_r11_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    ready && flush_req && push_req && occupancy != '0
    |=> spill_req && occupancy == $past(occupancy));
endmodule

bind frame_cache_ctrl fcc_checker #(
  .NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W), .CRIT_PRIO(CRIT_PRIO)
) i_fcc_checker (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
  .flush_req(flush_req), .rsv_frames(rsv_frames), .cur_prio(cur_prio),
  .cur_intr(cur_intr), .spill_ack(spill_ack), .fill_ack(fill_ack),
  .ready(ready), .spill_req(spill_req), .spill_slot(spill_slot),
  .fill_req(fill_req), .flush_done(flush_done), .occupancy(occupancy),
  .head_ptr(head_ptr)
);

// File: tb/test_frame_cache_ctrl.sv
module test_frame_cache_ctrl;
  localparam int N = 8;

  logic       clk;
  logic       rst_n;
  logic       push_req, pop_req, flush_req;
  logic [2:0] rsv_frames;
  logic [4:0] cur_prio;
  logic       cur_intr;
  logic       spill_ack, fill_ack;
  logic       ready, spill_req, fill_req, flush_done;
  logic [2:0] spill_slot;
  logic [3:0] occupancy;

  int n_tests = 0;
  int n_fail  = 0;
  int cnt     = 0;
  int oldest  = 0;
  int exp_q[$];

  frame_cache_ctrl i_frame_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .flush_req(flush_req), .rsv_frames(rsv_frames), .cur_prio(cur_prio),
    .cur_intr(cur_intr), .spill_ack(spill_ack), .fill_ack(fill_ack),
    .ready(ready), .spill_req(spill_req), .spill_slot(spill_slot),
    .fill_req(fill_req), .flush_done(flush_done), .occupancy(occupancy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // monitor: compares every acknowledged spill slot against the scoreboard (R6)
  always @(negedge clk) begin
    if (rst_n && spill_req && spill_ack) begin
      if (exp_q.size() == 0) chk("R6 unexpected spill", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk("R6 spill slot order", int'(spill_slot), e);
      end
    end
  end

  task automatic serve_spill(string req);
    chk({req, " spill_req"}, int'(spill_req), 1);
    chk("R7 ready low while spilling", int'(ready), 0);
    exp_q.push_back(oldest);
    spill_ack = 1'b1;
    step();
    spill_ack = 1'b0;
    cnt--;
    oldest = (oldest + 1) % N;
    chk("R6 occupancy after ack", int'(occupancy), cnt);
  endtask

  task automatic issue(bit p, bit q, bit f, int prio, bit intr, int r, string req);
    push_req = p; pop_req = q; flush_req = f;
    cur_prio = 5'(prio); cur_intr = intr; rsv_frames = 3'(r);
    step();
    push_req = 1'b0; pop_req = 1'b0; flush_req = 1'b0;
    if (f) begin
      if (cnt == 0) begin
        chk({req, " R9 done on empty"}, int'(flush_done), 1);
      end else begin
        chk({req, " R9 draining"}, int'(spill_req), 1);
        while (cnt > 0) begin
          chk("R9 no early done", int'(flush_done), 0);
          serve_spill("R9");
        end
        chk("R9 done pulse", int'(flush_done), 1);
      end
      chk("R9 occupancy zero", int'(occupancy), 0);
      step();
      chk("R9 done one cycle", int'(flush_done), 0);
      chk("R9 ready after flush", int'(ready), 1);
    end else if (p) begin
      bit sp;
      cnt++;
      sp = (cnt == N) || (!(intr && prio >= 28) && (cnt + r >= N));
      chk({req, " R2 occupancy after push"}, int'(occupancy), cnt);
      chk({req, " spill decision"}, int'(spill_req), int'(sp));
      if (sp) serve_spill(req);
    end else if (q) begin
      if (cnt == 0) begin
        chk("R8 fill_req raised", int'(fill_req), 1);
        chk("R8 ready low", int'(ready), 0);
        step();
        chk("R8 fill_req held", int'(fill_req), 1);
        fill_ack = 1'b1;
        step();
        fill_ack = 1'b0;
        chk("R8 fill_req dropped", int'(fill_req), 0);
        chk("R8 occupancy stays 0", int'(occupancy), 0);
        chk("R8 ready back", int'(ready), 1);
      end else begin
        cnt--;
        chk({req, " R2 occupancy after pop"}, int'(occupancy), cnt);
        chk({req, " no spill on pop"}, int'(spill_req), 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    push_req = 0; pop_req = 0; flush_req = 0;
    rsv_frames = 0; cur_prio = 0; cur_intr = 0;
    spill_ack = 0; fill_ack = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset occupancy", int'(occupancy), 0);
    chk("R1 reset ready", int'(ready), 1);
    chk("R1 reset spill_req", int'(spill_req), 0);
    chk("R1 reset fill_req", int'(fill_req), 0);
    chk("R1 reset flush_done", int'(flush_done), 0);
    chk("R1 reset spill_slot", int'(spill_slot), 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", int'(occupancy), 0);

    // R2: plain pushes and a pop
    repeat (3) issue(1, 0, 0, 5, 0, 0, "R2");
    issue(0, 1, 0, 5, 0, 0, "R2");
    // R4: R=2, non-critical spills once six would be resident
    repeat (4) issue(1, 0, 0, 5, 0, 2, "R4");
    // R5/R3: critical code fills to 8, spills only there
    repeat (3) issue(1, 0, 0, 28, 1, 2, "R5");
    // R3: non-critical push at 7 with R=0
    issue(1, 0, 0, 3, 0, 0, "R3");
    // R10: changing R then popping triggers no spill
    rsv_frames = 3'd7;
    step();
    chk("R10 no spill on R change", int'(spill_req), 0);
    issue(0, 1, 0, 3, 0, 7, "R10");
    // R10/R4: R=7, interrupted but low priority, and high priority not interrupted
    issue(1, 0, 0, 10, 1, 7, "R10");
    issue(1, 0, 0, 30, 0, 7, "R4");
    // R5: critical with R=7 does not spill below full
    issue(1, 0, 0, 31, 1, 7, "R5");
    // R7: stall while a spill is outstanding
    push_req = 1; cur_prio = 1; cur_intr = 0; rsv_frames = 0;
    step();
    push_req = 0;
    cnt++;
    chk("R3 spill at full", int'(spill_req), 1);
    begin
      int slot0;
      slot0 = int'(spill_slot);
      pop_req = 1; flush_req = 1;
      step(); step();
      chk("R7 occupancy frozen", int'(occupancy), cnt);
      chk("R6 spill still held", int'(spill_req), 1);
      chk("R6 slot stable", int'(spill_slot), slot0);
      pop_req = 0; flush_req = 0;
    end
    serve_spill("R7");
    chk("R7 ignored requests", int'(ready), 1);
    // R9: flush everything, then flush at empty
    issue(0, 0, 1, 0, 0, 0, "R9");
    issue(0, 0, 1, 0, 0, 0, "R9");
    // R8: pop at empty
    issue(0, 1, 0, 0, 0, 0, "R8");
    // R11: precedence
    issue(1, 1, 1, 0, 0, 0, "R11");
    chk("R11 flush wins", int'(occupancy), 0);
    issue(1, 1, 0, 0, 0, 0, "R11");
    chk("R11 push beats pop", int'(occupancy), 1);
    issue(1, 0, 0, 0, 0, 0, "R2");
    issue(0, 0, 1, 0, 0, 0, "R9");
    chk("R6 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule